// File: doc/BRIEF.md
# LCD Sync Timing Generator

This block produces the raster timing for a parallel RGB LCD panel: horizontal sync, vertical sync, data enable, the coordinates of the active pixel, and a pixel-rate enable that marks each pixel period. Each dimension passes through four phases in a fixed order: sync, back porch, active, front porch. The length of each phase comes from a configuration field that holds the length minus one. A divider can pass the system clock through unchanged or slow the pixel rate so that each pixel lasts several system clocks.

A controller state machine with two states decides whether the raster runs. In `ST_IDLE` the counters are held at the frame origin and every output sits at its inactive level. The `START` transition moves `ST_IDLE` to `ST_RUN` on the first clock edge that samples the video enable high. At the last clock of every frame the controller takes one of two transitions. `WRAP` stays in `ST_RUN` when the enable is still high. `STOP` returns to `ST_IDLE` when the enable has been cleared, so a frame is never cut short.

The timing and divider fields are copied into shadow registers. The copy is refreshed on every clock while idle and otherwise only at the last clock of a frame, so software can rewrite them at any time. A one-cycle frame-start strobe marks the leading edge of vertical sync, and a one-cycle frame-end strobe marks the last clock of the frame for shadow updates and interrupts. The output levels of the sync and enable signals can be inverted per signal.

Top module: `lcd_sync_gen`

## Requirements
- R1: After reset, with `inv_sel` = 0, `lcd_hsync`, `lcd_vsync`, `lcd_de`, `pix_x`, `pix_y`, `pix_tick`, `frame_start` and `frame_end` are all 0.
- R2: While `video_on` is low and the controller is idle, the sync and enable outputs stay at their inactive levels, the coordinates stay 0 and no strobe or tick is produced.
- R3: A line is, in order, (h_sync_m1+1) sync pixels with hsync active, then (h_back_m1+1) back porch pixels, then (h_act_m1+1) active pixels, then (h_front_m1+1) front porch pixels.
- R4: A frame is, in order, (v_sync_m1+1) lines with vsync active, then (v_back_m1+1) back porch lines, then (v_act_m1+1) active lines, then (v_front_m1+1) front porch lines.
- R5: `lcd_de` is active only when both dimensions are in their active phase. `pix_x` counts from 0 across the horizontal active phase and `pix_y` counts from 0 across the vertical active phase. Each coordinate is 0 outside its active phase.
- R6: With `div_on` = 0 every clock is one pixel and `pix_tick` is always high while running. With `div_on` = 1 each pixel lasts (div_val+1) clocks and `pix_tick` is high on the last of them.
- R7: The frame period is the product of the four horizontal lengths summed and the four vertical lengths summed, in pixels, times the clocks per pixel.
- R8: `frame_start` is high for exactly one clock: the first clock of the frame, which is the leading edge of vsync.
- R9: `frame_end` is high for exactly one clock: the last clock of the frame.
- R10: When `video_on` is cleared during a frame, that frame completes, and from the next clock the outputs are at their idle levels.
- R11: `inv_sel` bit 0 inverts `lcd_hsync`, bit 1 inverts `lcd_vsync` and bit 2 inverts `lcd_de`. This also applies to the idle levels.
- R12: Changes to the timing or divider fields while running take effect only at the start of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| video_on | input | 1 | Video enable; starts the raster, and clearing it stops the raster at the frame end |
| div_on | input | 1 | 0: one pixel per clock; 1: divide by div_val+1 |
| div_val | input | DIV_W | Divider value minus one |
| h_sync_m1 | input | PORCH_W | Horizontal sync width minus one |
| h_back_m1 | input | PORCH_W | Horizontal back porch minus one |
| h_front_m1 | input | PORCH_W | Horizontal front porch minus one |
| h_act_m1 | input | SIZE_W | Active pixels per line minus one |
| v_sync_m1 | input | PORCH_W | Vertical sync width minus one, in lines |
| v_back_m1 | input | PORCH_W | Vertical back porch minus one, in lines |
| v_front_m1 | input | PORCH_W | Vertical front porch minus one, in lines |
| v_act_m1 | input | SIZE_W | Active lines minus one |
| inv_sel | input | 3 | Output inversion: bit0 hsync, bit1 vsync, bit2 data enable |
| lcd_hsync | output | 1 | Horizontal sync |
| lcd_vsync | output | 1 | Vertical sync |
| lcd_de | output | 1 | Data enable |
| pix_x | output | SIZE_W | Horizontal active coordinate |
| pix_y | output | SIZE_W | Vertical active coordinate |
| pix_tick | output | 1 | High on the last clock of each pixel while running |
| frame_start | output | 1 | One-clock strobe at the first clock of a frame |
| frame_end | output | 1 | One-clock strobe at the last clock of a frame |

## Verification
The assertions check local invariants on every cycle. Phase counters stay within the length of their phase, phases advance in order, data enable never overlaps a sync pulse, both strobes last a single clock, and the controller leaves the running state only at a frame end. The exact lengths of the phases, the coordinate values, the frame period under the divider, the deferred stop and the deferred adoption of rewritten fields can only be shown by the bench. Its scoreboard compares every clock of whole frames against a raster it builds independently from the configuration.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
    localparam int DEF_PORCH_W = 8;
    localparam int DEF_SIZE_W  = 11;
    localparam int DEF_DIV_W   = 8;
    localparam int N_POL       = 3;

    typedef enum logic [1:0] {
        PH_SYNC   = 2'd0,
        PH_BACK   = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_FRONT  = 2'd3
    } phase_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ctl_state_t;
endpackage

// File: rtl/lcdt_clkdiv.sv
module lcdt_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             div_on,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick,
    output logic             first
);
    logic [DIV_W-1:0] cnt;

    always_comb begin
        tick  = !div_on || (cnt == div_val);
        first = (cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6: with a divide ratio above one, a tick is followed by a non-tick cycle
    a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_on && div_val != '0 && !clear) |=> (!tick || !$stable(div_val) || !div_on));
endmodule

// File: rtl/lcdt_axis.sv
module lcdt_axis
    import lcdt_pkg::*;
#(
    parameter int PORCH_W = 8,
    parameter int SIZE_W  = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               step,
    input  logic [PORCH_W-1:0] sync_m1,
    input  logic [PORCH_W-1:0] back_m1,
    input  logic [PORCH_W-1:0] front_m1,
    input  logic [SIZE_W-1:0]  act_m1,
    output phase_t             phase,
    output logic [SIZE_W-1:0]  count,
    output logic               last
);
    localparam int EXT_W = SIZE_W - PORCH_W;

    logic [SIZE_W-1:0] limit;
    logic              phase_end;
    phase_t            phase_nxt;

    always_comb begin
        limit     = '0;
        phase_nxt = PH_SYNC;
        unique case (phase)
            PH_SYNC: begin
                limit     = {{EXT_W{1'b0}}, sync_m1};
                phase_nxt = PH_BACK;
            end
            PH_BACK: begin
                limit     = {{EXT_W{1'b0}}, back_m1};
                phase_nxt = PH_ACTIVE;
            end
            PH_ACTIVE: begin
                limit     = act_m1;
                phase_nxt = PH_FRONT;
            end
            PH_FRONT: begin
                limit     = {{EXT_W{1'b0}}, front_m1};
                phase_nxt = PH_SYNC;
            end
        endcase
        phase_end = (count == limit);
        last      = (phase == PH_FRONT) && phase_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_SYNC;
            count <= '0;
        end else if (clear) begin
            phase <= PH_SYNC;
            count <= '0;
        end else if (step) begin
            if (phase_end) begin
                phase <= phase_nxt;
                count <= '0;
            end else begin
                count <= count + 1'b1;
            end
        end
    end

    // R3 / R4: the counter never runs past the length of its phase
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= limit);

    // R3 / R4: the back porch is always followed by the active phase
    a_r3_back_then_active: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && phase_end && phase == PH_BACK) |=> (phase == PH_ACTIVE));

    // R4: the front porch wraps to the sync phase at count zero
    a_r4_front_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && last) |=> (phase == PH_SYNC && count == '0));
endmodule

// File: rtl/lcdt_ctrl.sv
module lcdt_ctrl
    import lcdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic video_on,
    input  logic frame_done,
    output logic run,
    output logic load_cfg
);
    ctl_state_t state;
    ctl_state_t state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (video_on) state_nxt = ST_RUN;            // START
            ST_RUN:  if (frame_done && !video_on) state_nxt = ST_IDLE; // STOP, else WRAP
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        run      = 1'b0;
        load_cfg = 1'b0;
        unique case (state)
            ST_IDLE: begin
                run      = 1'b0;
                load_cfg = 1'b1;
            end
            ST_RUN: begin
                run      = 1'b1;
                load_cfg = frame_done;
            end
        endcase
    end

    // R10: the raster is left only at the end of a frame
    a_r10_stop_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !frame_done) |=> (state == ST_RUN));

    // R2: nothing starts while the enable is low
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !video_on) |=> (state == ST_IDLE));
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
    import lcdt_pkg::*;
#(
    parameter int PORCH_W = DEF_PORCH_W,
    parameter int SIZE_W  = DEF_SIZE_W,
    parameter int DIV_W   = DEF_DIV_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               video_on,
    input  logic               div_on,
    input  logic [DIV_W-1:0]   div_val,
    input  logic [PORCH_W-1:0] h_sync_m1,
    input  logic [PORCH_W-1:0] h_back_m1,
    input  logic [PORCH_W-1:0] h_front_m1,
    input  logic [SIZE_W-1:0]  h_act_m1,
    input  logic [PORCH_W-1:0] v_sync_m1,
    input  logic [PORCH_W-1:0] v_back_m1,
    input  logic [PORCH_W-1:0] v_front_m1,
    input  logic [SIZE_W-1:0]  v_act_m1,
    input  logic [N_POL-1:0]   inv_sel,
    output logic               lcd_hsync,
    output logic               lcd_vsync,
    output logic               lcd_de,
    output logic [SIZE_W-1:0]  pix_x,
    output logic [SIZE_W-1:0]  pix_y,
    output logic               pix_tick,
    output logic               frame_start,
    output logic               frame_end
);
    // shadow copies of the configuration
    logic               sh_div_on;
    logic [DIV_W-1:0]   sh_div_val;
    logic [PORCH_W-1:0] sh_h_sync, sh_h_back, sh_h_front;
    logic [PORCH_W-1:0] sh_v_sync, sh_v_back, sh_v_front;
    logic [SIZE_W-1:0]  sh_h_act, sh_v_act;

    logic               run, load_cfg, frame_done;
    logic               tick, div_first;
    phase_t             h_phase, v_phase;
    logic [SIZE_W-1:0]  h_count, v_count;
    logic               h_last, v_last;
    logic [N_POL-1:0]   raw_lvl;
    logic [N_POL-1:0]   out_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_div_on  <= 1'b0;
            sh_div_val <= '0;
            sh_h_sync  <= '0;
            sh_h_back  <= '0;
            sh_h_front <= '0;
            sh_h_act   <= '0;
            sh_v_sync  <= '0;
            sh_v_back  <= '0;
            sh_v_front <= '0;
            sh_v_act   <= '0;
        end else if (load_cfg) begin
            sh_div_on  <= div_on;
            sh_div_val <= div_val;
            sh_h_sync  <= h_sync_m1;
            sh_h_back  <= h_back_m1;
            sh_h_front <= h_front_m1;
            sh_h_act   <= h_act_m1;
            sh_v_sync  <= v_sync_m1;
            sh_v_back  <= v_back_m1;
            sh_v_front <= v_front_m1;
            sh_v_act   <= v_act_m1;
        end
    end

    lcdt_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .video_on   (video_on),
        .frame_done (frame_done),
        .run        (run),
        .load_cfg   (load_cfg)
    );

    lcdt_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!run),
        .div_on  (sh_div_on),
        .div_val (sh_div_val),
        .tick    (tick),
        .first   (div_first)
    );

    lcdt_axis #(.PORCH_W(PORCH_W), .SIZE_W(SIZE_W)) u_h (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!run),
        .step     (run && tick),
        .sync_m1  (sh_h_sync),
        .back_m1  (sh_h_back),
        .front_m1 (sh_h_front),
        .act_m1   (sh_h_act),
        .phase    (h_phase),
        .count    (h_count),
        .last     (h_last)
    );

    lcdt_axis #(.PORCH_W(PORCH_W), .SIZE_W(SIZE_W)) u_v (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!run),
        .step     (run && tick && h_last),
        .sync_m1  (sh_v_sync),
        .back_m1  (sh_v_back),
        .front_m1 (sh_v_front),
        .act_m1   (sh_v_act),
        .phase    (v_phase),
        .count    (v_count),
        .last     (v_last)
    );

    always_comb begin
        frame_done  = run && tick && h_last && v_last;
        raw_lvl[0]  = run && (h_phase == PH_SYNC);
        raw_lvl[1]  = run && (v_phase == PH_SYNC);
        raw_lvl[2]  = run && (h_phase == PH_ACTIVE) && (v_phase == PH_ACTIVE);
        pix_x       = (run && h_phase == PH_ACTIVE) ? h_count : '0;
        pix_y       = (run && v_phase == PH_ACTIVE) ? v_count : '0;
        pix_tick    = run && tick;
        frame_start = run && div_first && (h_phase == PH_SYNC) && (h_count == '0)
                      && (v_phase == PH_SYNC) && (v_count == '0);
        frame_end   = frame_done;
    end

    // R11: per-signal output inversion
    for (genvar gi = 0; gi < N_POL; gi++) begin : g_pol
        assign out_lvl[gi] = raw_lvl[gi] ^ inv_sel[gi];
    end

    assign lcd_hsync = out_lvl[0];
    assign lcd_vsync = out_lvl[1];
    assign lcd_de    = out_lvl[2];

    // R5: data enable never coincides with either sync pulse
    a_r5_de_outside_sync: assert property (@(posedge clk) disable iff (!rst_n)
        raw_lvl[2] |-> (!raw_lvl[0] && !raw_lvl[1]));

    // R8: frame start lasts one clock
    a_r8_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    // R9: a frame end is followed by a new frame start or by idle
    a_r9_end_then_start: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (frame_start || !run));

    // R2: idle keeps every raw output quiet
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (raw_lvl == '0 && !frame_start && !pix_tick));
endmodule

// File: tb/tb_lcd_sync_gen.sv
`timescale 1ns/1ps
module tb_lcd_sync_gen;
    localparam int PW = 8;
    localparam int SW = 11;
    localparam int DW = 8;

    typedef struct {
        int hs, hb, ha, hf;
        int vs, vb, va, vf;
        bit den;
        int dval;
        bit [2:0] inv;
    } cfg_t;

    typedef struct {
        bit hs, vs, de, tk, fs, fe;
        int x, y;
        int tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic video_on = 1'b0;
    logic div_on = 1'b0;
    logic [DW-1:0] div_val = '0;
    logic [PW-1:0] h_sync_m1 = '0, h_back_m1 = '0, h_front_m1 = '0;
    logic [PW-1:0] v_sync_m1 = '0, v_back_m1 = '0, v_front_m1 = '0;
    logic [SW-1:0] h_act_m1 = '0, v_act_m1 = '0;
    logic [2:0] inv_sel = '0;
    logic lcd_hsync, lcd_vsync, lcd_de, pix_tick, frame_start, frame_end;
    logic [SW-1:0] pix_x, pix_y;

    always #2.5 clk = ~clk;

    lcd_sync_gen #(.PORCH_W(PW), .SIZE_W(SW), .DIV_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .video_on(video_on), .div_on(div_on), .div_val(div_val),
        .h_sync_m1(h_sync_m1), .h_back_m1(h_back_m1), .h_front_m1(h_front_m1), .h_act_m1(h_act_m1),
        .v_sync_m1(v_sync_m1), .v_back_m1(v_back_m1), .v_front_m1(v_front_m1), .v_act_m1(v_act_m1),
        .inv_sel(inv_sel), .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync), .lcd_de(lcd_de),
        .pix_x(pix_x), .pix_y(pix_y), .pix_tick(pix_tick),
        .frame_start(frame_start), .frame_end(frame_end)
    );

    int checks = 0;
    int fails = 0;
    int printed = 0;
    bit finished = 0;
    exp_t exp_q[$];
    int cyc = 0;
    int last_fs = -1;
    int period_seen = -1;

    task automatic report(input string req, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            if (printed < 25) begin
                $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", req, what, cyc, act, expv);
                printed++;
            end
        end
    endtask

    function automatic int frame_len(input cfg_t c);
        // R7: frame period = horizontal total * vertical total * clocks per pixel
        int ht = c.hs + c.hb + c.ha + c.hf + 4;
        int vt = c.vs + c.vb + c.va + c.vf + 4;
        return ht * vt * (c.den ? c.dval + 1 : 1);
    endfunction

    task automatic push_idle(input cfg_t c, input int tag);
        exp_t e;
        e.hs = c.inv[0]; e.vs = c.inv[1]; e.de = c.inv[2];
        e.tk = 0; e.fs = 0; e.fe = 0; e.x = 0; e.y = 0; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic push_frame(input cfg_t c);
        int ht = c.hs + c.hb + c.ha + c.hf + 4;
        int vt = c.vs + c.vb + c.va + c.vf + 4;
        int dv = c.den ? c.dval + 1 : 1;
        int h0 = c.hs + c.hb + 2;
        int v0 = c.vs + c.vb + 2;
        for (int v = 0; v < vt; v++) begin
            for (int h = 0; h < ht; h++) begin
                for (int d = 0; d < dv; d++) begin
                    exp_t e;
                    bit ha, va;
                    ha = (h >= h0) && (h < h0 + c.ha + 1);
                    va = (v >= v0) && (v < v0 + c.va + 1);
                    e.hs = (h <= c.hs) ^ c.inv[0];
                    e.vs = (v <= c.vs) ^ c.inv[1];
                    e.de = (ha && va) ^ c.inv[2];
                    e.x = ha ? h - h0 : 0;
                    e.y = va ? v - v0 : 0;
                    e.tk = (d == dv - 1);
                    e.fs = (v == 0 && h == 0 && d == 0);
                    e.fe = (v == vt - 1 && h == ht - 1 && d == dv - 1);
                    e.tag = 0;
                    exp_q.push_back(e);
                end
            end
        end
    endtask

    task automatic apply_cfg(input cfg_t c);
        h_sync_m1 = PW'(c.hs); h_back_m1 = PW'(c.hb); h_front_m1 = PW'(c.hf); h_act_m1 = SW'(c.ha);
        v_sync_m1 = PW'(c.vs); v_back_m1 = PW'(c.vb); v_front_m1 = PW'(c.vf); v_act_m1 = SW'(c.va);
        div_on = c.den; div_val = DW'(c.dval); inv_sel = c.inv;
    endtask

    // driver: two frames (c1 then c2), enable cleared during the last frame
    task automatic run_seq(input cfg_t c1, input cfg_t c2, input int nfr);
        @(posedge clk); #1;
        apply_cfg(c1);
        @(posedge clk); #1;
        last_fs = -1; period_seen = -1;
        video_on = 1'b1;
        push_idle(c1, 0);
        push_frame(c1);
        if (nfr == 2) push_frame(c2);
        for (int i = 0; i < 3; i++) push_idle(c2, 10); // R10 idle after stop
        if (nfr == 2) begin
            repeat (3) @(posedge clk);
            #1 apply_cfg(c2); // R12: rewritten mid-frame
        end
        while (exp_q.size() >= frame_len(nfr == 2 ? c2 : c1) + 2) @(posedge clk);
        #1 video_on = 1'b0;
        while (exp_q.size() > 0) @(posedge clk);
        @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        cyc++;
        if (rst_n && frame_start) begin
            if (last_fs >= 0) period_seen = cyc - last_fs;
            last_fs = cyc;
        end
        if (exp_q.size() > 0) begin
            exp_t e;
            string t;
            e = exp_q.pop_front();
            checks++;
            t = "";
            if (e.tag == 2) t = "R2";
            else if (e.tag == 10) t = "R10";
            if (lcd_hsync !== e.hs) t = (t != "") ? t : "R3";
            else if (lcd_vsync !== e.vs) t = (t != "") ? t : "R4";
            else if (lcd_de !== e.de || int'(pix_x) != e.x || int'(pix_y) != e.y) t = (t != "") ? t : "R5";
            else if (pix_tick !== e.tk) t = (t != "") ? t : "R6";
            else if (frame_start !== e.fs) t = (t != "") ? t : "R8";
            else if (frame_end !== e.fe) t = (t != "") ? t : "R9";
            else t = "";
            if (t != "") begin
                fails++;
                if (printed < 25) begin
                    $display("FAIL %s cycle %0d: actual hs=%0b vs=%0b de=%0b x=%0d y=%0d tk=%0b fs=%0b fe=%0b expected hs=%0b vs=%0b de=%0b x=%0d y=%0d tk=%0b fs=%0b fe=%0b",
                        t, cyc, lcd_hsync, lcd_vsync, lcd_de, pix_x, pix_y, pix_tick, frame_start, frame_end,
                        e.hs, e.vs, e.de, e.x, e.y, e.tk, e.fs, e.fe);
                    printed++;
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog expired: actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        cfg_t ca, cb, cc, cd;
        ca = '{hs:0, hb:1, ha:3, hf:0, vs:0, vb:0, va:2, vf:1, den:0, dval:0, inv:3'b000};
        cb = '{hs:1, hb:0, ha:4, hf:1, vs:1, vb:1, va:1, vf:0, den:1, dval:2, inv:3'b111};
        cc = ca; cc.den = 1; cc.dval = 0;
        cd = cb; cd.dval = 1; cd.inv = 3'b000;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        report("R1", "hsync", lcd_hsync, 0);
        report("R1", "vsync", lcd_vsync, 0);
        report("R1", "de", lcd_de, 0);
        report("R1", "x+y", int'(pix_x) + int'(pix_y), 0);
        report("R1", "strobes", {pix_tick, frame_start, frame_end}, 0);
        #1 rst_n = 1'b1;

        // R2: configured but not enabled
        @(posedge clk); #1;
        apply_cfg(cb);
        for (int i = 0; i < 8; i++) push_idle(cb, 2);
        while (exp_q.size() > 0) @(posedge clk);
        @(negedge clk);
        // R11: inverted idle levels
        report("R11", "idle hsync inverted", lcd_hsync, 1);
        report("R11", "idle vsync inverted", lcd_vsync, 1);
        report("R11", "idle de inverted", lcd_de, 1);

        // R3 R4 R5 R7: bypass clock, two identical frames
        run_seq(ca, ca, 2);
        report("R7", "frame period", period_seen, frame_len(ca));

        // R6 R11: divide by three, inverted outputs
        run_seq(cb, cb, 2);
        report("R6", "divided frame period", period_seen, frame_len(cb));

        // R12: divider enabled at ratio one, rewritten mid-frame
        run_seq(cc, cd, 2);
        report("R12", "first frame kept old timing", period_seen, frame_len(cc));

        // R10: single frame with early stop
        run_seq(ca, ca, 1);
        report("R10", "idle de after stop", lcd_de, 0);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule